// File: doc/BRIEF.md
# PRD Scatter-Gather DMA Walker

This block moves a device buffer between a storage device and main memory when that memory is scattered across several regions. Software builds a table of 8-byte descriptors in memory; each descriptor gives the start address of one region, its byte count and a flag that ends the table. After a start pulse the walker reads the table one descriptor at a time through a simple descriptor read port. For each region it issues memory burst requests over a valid/ready handshake until that region or the device buffer is used up, and then it fetches the next descriptor.

The walker does not carry the data. Each request names the memory address, the length in bytes, the direction and the offset into the device buffer, so a data mover beside it can copy the bytes. The walk ends with a one-cycle done pulse. The pulse comes with a short flag when the table ran out before the whole device buffer was placed. A fail-safe bound stops a table that has no end marker after one 4 KiB page of descriptors.

Top module: `prd_walker`

## Requirements
- R1: The descriptor port returns one 64-bit word per fetch. Bits 31:0 are the region address and bits 63:32 are the size/flags word, which follows the address in little-endian memory order.
- R2: The region byte count is size-word bits 15:1 times two (descriptor bits 47:33). Size-word bit 0 is ignored, so every region has an even length.
- R3: A byte-count field of zero makes a region of 65536 bytes.
- R4: Size-word bit 31 (descriptor bit 63) marks the final descriptor. No further descriptor is fetched after that region has been used up.
- R5: Descriptor fetches read the table base first and then addresses 8 bytes apart in increasing order. The fetch address holds steady until the fetch is acknowledged.
- R6: When a region is used up and the table pointer is 4096 or more bytes past the base, the walk stops with the short flag. At most 512 descriptors are read per walk.
- R7: Each memory request has a length equal to the smallest of the bytes left in the device buffer, the bytes left in the region, and the burst size (256). Region address and buffer offset advance by that length, with offsets starting at 0.
- R8: When the device buffer is exhausted the walk ends with done and no short flag, and no further descriptor is fetched. A device byte count of zero ends at once with no fetch.
- R9: If the table ends before the device buffer is exhausted, done is pulsed with short = 1. Short is only ever high together with done.
- R10: A start clears the current region, its length and the final flag, so the first action of every walk is a fetch at the new base, even if the previous walk left bytes in a region.
- R11: The write flag of every request equals the direction sampled at start: 1 means device-to-memory (memory write), 0 means memory-to-device (memory read).
- R12: A request with valid high and ready low keeps valid, address, length and offset unchanged in the next cycle.
- R13: After reset the walker is idle: busy, done, short, descriptor request and memory valid are all low. A start is accepted only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken while idle |
| dir_i | input | 1 | 1 device-to-memory, 0 memory-to-device |
| table_base_i | input | ADDR_W | Address of the first descriptor |
| byte_count_i | input | CNT_W | Device buffer size in bytes |
| desc_req_o | output | 1 | Descriptor fetch request |
| desc_addr_o | output | ADDR_W | Descriptor fetch address |
| desc_ack_i | input | 1 | Fetch acknowledge, data valid |
| desc_data_i | input | 64 | Descriptor: size/flags in 63:32, address in 31:0 |
| mreq_valid_o | output | 1 | Memory burst request valid |
| mreq_ready_i | input | 1 | Memory burst request accepted |
| mreq_write_o | output | 1 | 1 memory write, 0 memory read |
| mreq_addr_o | output | ADDR_W | Burst start address |
| mreq_len_o | output | BURST_W | Burst length in bytes |
| mreq_offset_o | output | CNT_W | Offset into the device buffer |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| short_o | output | 1 | With done: table ended before buffer |

## Verification
The assertions check, on every cycle, the properties that need no knowledge of the table contents: handshake stability on both ports, burst length bounds, contiguous buffer offsets, the direction flag, the first fetch landing on the base, the 512-descriptor ceiling and short appearing only with done. Whether lengths are decoded correctly, where region addresses come from, when the final flag ends the walk and whether short is reported correctly all depend on what is in memory. Only the bench scenarios can show these: they compare every fetch and every request against a walk of the same table done in the bench, with directed tables for zero-length, odd-length, unterminated and early-exhaust cases mixed with random tables and random stalls.

// File: rtl/prd_pkg.sv
package prd_pkg;

    localparam int DESC_BYTES   = 8;
    localparam int LAST_BIT     = 63;
    localparam int CNT_HI_BIT   = 47;
    localparam int CNT_LO_BIT   = 33;
    localparam int MAX_REGION   = 65536;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WALK  = 3'd1,
        ST_FETCH = 3'd2,
        ST_ISSUE = 3'd3,
        ST_DONE  = 3'd4
    } walk_state_e;

endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode #(
    parameter int ADDR_W = 32,
    parameter int RLEN_W = 17
) (
    input  logic [63:0]       desc_i,
    output logic [ADDR_W-1:0] region_addr_o,
    output logic [RLEN_W-1:0] region_len_o,
    output logic              last_o
);
    import prd_pkg::*;

    localparam int FIELD_W = CNT_HI_BIT - CNT_LO_BIT + 1;

    logic [FIELD_W-1:0] half_count;
    logic               unused_desc_bits;

    assign unused_desc_bits = ^{desc_i[62:48], desc_i[32]};
    assign half_count       = desc_i[CNT_HI_BIT:CNT_LO_BIT];
    assign region_addr_o    = ADDR_W'(desc_i[31:0]);
    assign last_o           = desc_i[LAST_BIT];

    always_comb begin
        if (half_count == '0) begin
            region_len_o = RLEN_W'(MAX_REGION);
        end else begin
            region_len_o = RLEN_W'({half_count, 1'b0});
        end
    end

endmodule

// File: rtl/prd_chunk_sel.sv
module prd_chunk_sel #(
    parameter int CNT_W       = 24,
    parameter int RLEN_W      = 17,
    parameter int BURST_BYTES = 256,
    parameter int BURST_W     = 9
) (
    input  logic [CNT_W-1:0]   remaining_i,
    input  logic [RLEN_W-1:0]  region_left_i,
    output logic [BURST_W-1:0] chunk_o
);
    localparam int W = ((CNT_W > RLEN_W) ? CNT_W : RLEN_W) + 1;

    logic [W-1:0] a_ext;
    logic [W-1:0] b_ext;
    logic [W-1:0] cap;
    logic [W-1:0] min_ab;
    logic [W-1:0] min_all;

    always_comb begin
        a_ext   = W'(remaining_i);
        b_ext   = W'(region_left_i);
        cap     = W'(BURST_BYTES);
        min_ab  = (a_ext < b_ext) ? a_ext : b_ext;
        min_all = (min_ab < cap) ? min_ab : cap;
        chunk_o = BURST_W'(min_all);
    end

endmodule

// File: rtl/prd_fence.sv
module prd_fence #(
    parameter int ADDR_W      = 32,
    parameter int TABLE_LIMIT = 4096
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] walked;

    assign walked = ptr_i - base_i;
    assign hit_o  = (walked >= ADDR_W'(TABLE_LIMIT));

endmodule

// File: rtl/prd_walker.sv
module prd_walker #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int BURST_BYTES = 256,
    parameter int TABLE_LIMIT = 4096,
    localparam int RLEN_W     = 17,
    localparam int BURST_W    = $clog2(BURST_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               dir_i,
    input  logic [ADDR_W-1:0]  table_base_i,
    input  logic [CNT_W-1:0]   byte_count_i,
    output logic               desc_req_o,
    output logic [ADDR_W-1:0]  desc_addr_o,
    input  logic               desc_ack_i,
    input  logic [63:0]        desc_data_i,
    output logic               mreq_valid_o,
    input  logic               mreq_ready_i,
    output logic               mreq_write_o,
    output logic [ADDR_W-1:0]  mreq_addr_o,
    output logic [BURST_W-1:0] mreq_len_o,
    output logic [CNT_W-1:0]   mreq_offset_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               short_o
);
    import prd_pkg::*;

    typedef struct packed {
        walk_state_e       state;
        logic              dir;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  rem;
        logic [CNT_W-1:0]  idx;
        logic [ADDR_W-1:0] raddr;
        logic [RLEN_W-1:0] rlen;
        logic              last;
        logic              short_f;
    } walk_t;

    walk_t walk_d;
    walk_t walk_q;

    logic [ADDR_W-1:0]  dec_addr;
    logic [RLEN_W-1:0]  dec_len;
    logic               dec_last;
    logic [BURST_W-1:0] chunk;
    logic               fence_hit;

    prd_desc_decode #(
        .ADDR_W (ADDR_W),
        .RLEN_W (RLEN_W)
    ) u_decode (
        .desc_i        (desc_data_i),
        .region_addr_o (dec_addr),
        .region_len_o  (dec_len),
        .last_o        (dec_last)
    );

    prd_chunk_sel #(
        .CNT_W       (CNT_W),
        .RLEN_W      (RLEN_W),
        .BURST_BYTES (BURST_BYTES),
        .BURST_W     (BURST_W)
    ) u_chunk (
        .remaining_i   (walk_q.rem),
        .region_left_i (walk_q.rlen),
        .chunk_o       (chunk)
    );

    prd_fence #(
        .ADDR_W      (ADDR_W),
        .TABLE_LIMIT (TABLE_LIMIT)
    ) u_fence (
        .base_i (walk_q.base),
        .ptr_i  (walk_q.ptr),
        .hit_o  (fence_hit)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    walk_d.dir     = dir_i;
                    walk_d.base    = table_base_i;
                    walk_d.ptr     = table_base_i;
                    walk_d.rem     = byte_count_i;
                    walk_d.idx     = '0;
                    walk_d.raddr   = '0;
                    walk_d.rlen    = '0;
                    walk_d.last    = 1'b0;
                    walk_d.short_f = 1'b0;
                    walk_d.state   = ST_WALK;
                end
            end
            ST_WALK: begin
                if (walk_q.rem == '0) begin
                    walk_d.short_f = 1'b0;
                    walk_d.state   = ST_DONE;
                end else if (walk_q.rlen == '0) begin
                    if (walk_q.last || fence_hit) begin
                        walk_d.short_f = 1'b1;
                        walk_d.state   = ST_DONE;
                    end else begin
                        walk_d.state = ST_FETCH;
                    end
                end else begin
                    walk_d.state = ST_ISSUE;
                end
            end
            ST_FETCH: begin
                if (desc_ack_i) begin
                    walk_d.raddr = dec_addr;
                    walk_d.rlen  = dec_len;
                    walk_d.last  = dec_last;
                    walk_d.ptr   = walk_q.ptr + ADDR_W'(DESC_BYTES);
                    walk_d.state = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mreq_ready_i) begin
                    walk_d.raddr = walk_q.raddr + ADDR_W'(chunk);
                    walk_d.rlen  = walk_q.rlen - RLEN_W'(chunk);
                    walk_d.rem   = walk_q.rem - CNT_W'(chunk);
                    walk_d.idx   = walk_q.idx + CNT_W'(chunk);
                    if (walk_d.rem == '0) begin
                        walk_d.short_f = 1'b0;
                        walk_d.state   = ST_DONE;
                    end else if (walk_d.rlen == '0) begin
                        walk_d.state = ST_WALK;
                    end
                end
            end
            ST_DONE: begin
                walk_d.state = ST_IDLE;
            end
            default: begin
                walk_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign desc_req_o    = (walk_q.state == ST_FETCH);
    assign desc_addr_o   = walk_q.ptr;
    assign mreq_valid_o  = (walk_q.state == ST_ISSUE);
    assign mreq_write_o  = walk_q.dir;
    assign mreq_addr_o   = walk_q.raddr;
    assign mreq_len_o    = chunk;
    assign mreq_offset_o = walk_q.idx;
    assign busy_o        = (walk_q.state != ST_IDLE);
    assign done_o        = (walk_q.state == ST_DONE);
    assign short_o       = (walk_q.state == ST_DONE) && walk_q.short_f;

endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int BURST_BYTES = 256,
    parameter int TABLE_LIMIT = 4096,
    parameter int BURST_W     = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               dir_i,
    input logic [ADDR_W-1:0]  table_base_i,
    input logic               desc_req_o,
    input logic [ADDR_W-1:0]  desc_addr_o,
    input logic               desc_ack_i,
    input logic               mreq_valid_o,
    input logic               mreq_ready_i,
    input logic               mreq_write_o,
    input logic [ADDR_W-1:0]  mreq_addr_o,
    input logic [BURST_W-1:0] mreq_len_o,
    input logic [CNT_W-1:0]   mreq_offset_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               short_o
);
    localparam int MAX_FETCH = TABLE_LIMIT / 8;
    localparam int FC_W      = $clog2(MAX_FETCH + 2) + 1;

    logic              taken;
    logic              dir_seen;
    logic [ADDR_W-1:0] base_seen;
    logic              first_pend;
    logic [FC_W-1:0]   fetch_cnt;
    logic [CNT_W-1:0]  exp_off;

    assign taken = start_i && !busy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_seen   <= 1'b0;
            base_seen  <= '0;
            first_pend <= 1'b0;
            fetch_cnt  <= '0;
            exp_off    <= '0;
        end else if (taken) begin
            dir_seen   <= dir_i;
            base_seen  <= table_base_i;
            first_pend <= 1'b1;
            fetch_cnt  <= '0;
            exp_off    <= '0;
        end else begin
            if (desc_req_o && desc_ack_i) begin
                first_pend <= 1'b0;
                fetch_cnt  <= fetch_cnt + 1'b1;
            end
            if (mreq_valid_o && mreq_ready_i) begin
                exp_off <= exp_off + CNT_W'(mreq_len_o);
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid_o && !mreq_ready_i |=> mreq_valid_o && $stable(mreq_addr_o)
            && $stable(mreq_len_o) && $stable(mreq_offset_o)); // R12
    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req_o && !desc_ack_i |=> desc_req_o && $stable(desc_addr_o)); // R5
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid_o |-> (mreq_len_o != '0) && (mreq_len_o <= BURST_W'(BURST_BYTES))); // R7
    AST_OFFSET_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid_o |-> mreq_offset_o == exp_off); // R7
    AST_SHORT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        short_o |-> done_o); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid_o |-> mreq_write_o == dir_seen); // R11
    AST_FETCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cnt <= FC_W'(MAX_FETCH)); // R6
    AST_FIRST_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req_o && first_pend |-> desc_addr_o == base_seen); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mreq_valid_o && !desc_req_o && !done_o); // R13

endmodule

bind prd_walker prd_walker_chk #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .BURST_BYTES (BURST_BYTES),
    .TABLE_LIMIT (TABLE_LIMIT),
    .BURST_W     (BURST_W)
) u_prd_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .dir_i         (dir_i),
    .table_base_i  (table_base_i),
    .desc_req_o    (desc_req_o),
    .desc_addr_o   (desc_addr_o),
    .desc_ack_i    (desc_ack_i),
    .mreq_valid_o  (mreq_valid_o),
    .mreq_ready_i  (mreq_ready_i),
    .mreq_write_o  (mreq_write_o),
    .mreq_addr_o   (mreq_addr_o),
    .mreq_len_o    (mreq_len_o),
    .mreq_offset_o (mreq_offset_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .short_o       (short_o)
);

// File: tb/tb_prd_walker.sv
`timescale 1ns/1ps
module tb_prd_walker;

    localparam int TBL_N = 520;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [31:0] table_base_i = '0;
    logic [23:0] byte_count_i = '0;
    logic        desc_req_o;
    logic [31:0] desc_addr_o;
    logic        desc_ack_i = 1'b0;
    logic [63:0] desc_data_i = '0;
    logic        mreq_valid_o;
    logic        mreq_ready_i = 1'b0;
    logic        mreq_write_o;
    logic [31:0] mreq_addr_o;
    logic [8:0]  mreq_len_o;
    logic [23:0] mreq_offset_o;
    logic        busy_o;
    logic        done_o;
    logic        short_o;

    prd_walker dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
        .table_base_i(table_base_i), .byte_count_i(byte_count_i),
        .desc_req_o(desc_req_o), .desc_addr_o(desc_addr_o),
        .desc_ack_i(desc_ack_i), .desc_data_i(desc_data_i),
        .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready_i),
        .mreq_write_o(mreq_write_o), .mreq_addr_o(mreq_addr_o),
        .mreq_len_o(mreq_len_o), .mreq_offset_o(mreq_offset_o),
        .busy_o(busy_o), .done_o(done_o), .short_o(short_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] tbl [TBL_N];

    logic [31:0] e_fetch[$];
    logic [31:0] e_addr[$];
    int          e_len[$];
    int          e_off[$];
    bit          e_short;
    logic [31:0] g_fetch[$];
    logic [31:0] g_addr[$];
    int          g_len[$];
    int          g_off[$];
    int          g_dir_bad;
    bit          g_short;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] mk_desc(input logic [31:0] addr,
                                            input logic [15:0] cnt, input bit last);
        return {last, 15'd0, cnt, addr};
    endfunction

    // Expected walk from the requirements (R2, R3, R4, R6, R7, R8, R9)
    task automatic model(input logic [31:0] base, input int bufn);
        int          rem;
        int          clen;
        int          ptr;
        int          off;
        int          ch;
        bit          last;
        logic [31:0] raddr;
        logic [63:0] d;
        e_fetch.delete(); e_addr.delete(); e_len.delete(); e_off.delete();
        rem = bufn; clen = 0; ptr = 0; off = 0; last = 0; raddr = '0;
        while (1) begin
            if (rem == 0) begin e_short = 0; break; end
            if (clen == 0) begin
                if (last || ptr >= 4096) begin e_short = 1; break; end
                d = tbl[ptr / 8];
                e_fetch.push_back(base + 32'(ptr));
                ptr = ptr + 8;
                raddr = d[31:0];
                clen = int'(d[47:33]) * 2;
                if (clen == 0) clen = 65536;
                last = d[63];
            end
            ch = rem;
            if (clen < ch) ch = clen;
            if (256 < ch) ch = 256;
            e_addr.push_back(raddr); e_len.push_back(ch); e_off.push_back(off);
            raddr = raddr + 32'(ch); clen = clen - ch; rem = rem - ch; off = off + ch;
        end
    endtask

    task automatic check(input bit ok, input string what);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s", what);
        end
    endtask

    task automatic run_case(input logic [31:0] base, input int bufn,
                            input bit dir, input string tag);
        int  idx;
        int  bad;
        bit  fin;
        model(base, bufn);
        g_fetch.delete(); g_addr.delete(); g_len.delete(); g_off.delete();
        g_dir_bad = 0; g_short = 0; fin = 0;
        @(negedge clk);
        start_i = 1'b1; dir_i = dir; table_base_i = base; byte_count_i = 24'(bufn);
        @(negedge clk);
        start_i = 1'b0;
        while (!fin) begin
            if (done_o) begin
                g_short = short_o;
                fin = 1;
            end else begin
                mreq_ready_i = ($urandom % 4) != 0;
                if (mreq_valid_o && mreq_ready_i) begin
                    g_addr.push_back(mreq_addr_o);
                    g_len.push_back(int'(mreq_len_o));
                    g_off.push_back(int'(mreq_offset_o));
                    if (mreq_write_o != dir) g_dir_bad = g_dir_bad + 1;
                end
                desc_ack_i = ($urandom % 3) != 0;
                if (desc_req_o && desc_ack_i) begin
                    idx = int'((desc_addr_o - base) >> 3);
                    desc_data_i = (idx >= 0 && idx < TBL_N) ? tbl[idx] : 64'd0;
                    g_fetch.push_back(desc_addr_o);
                end
                @(negedge clk);
            end
        end
        mreq_ready_i = 1'b0; desc_ack_i = 1'b0;
        bad = (g_fetch.size() != e_fetch.size()) ? 1 : 0;
        for (int i = 0; i < g_fetch.size() && i < e_fetch.size(); i++)
            if (g_fetch[i] != e_fetch[i]) bad = 1;
        check(bad == 0, $sformatf("%s R5 fetch list: got %0d fetches first %h, exp %0d first %h",
              tag, g_fetch.size(), (g_fetch.size() > 0) ? g_fetch[0] : 32'h0,
              e_fetch.size(), (e_fetch.size() > 0) ? e_fetch[0] : 32'h0));
        bad = (g_addr.size() != e_addr.size()) ? 1 : 0;
        for (int i = 0; i < g_addr.size() && i < e_addr.size(); i++) begin
            if (bad == 0 && (g_addr[i] != e_addr[i] || g_len[i] != e_len[i] || g_off[i] != e_off[i])) begin
                bad = 1;
                $display("  %s mismatch at request %0d: got addr=%h len=%0d off=%0d exp addr=%h len=%0d off=%0d",
                         tag, i, g_addr[i], g_len[i], g_off[i], e_addr[i], e_len[i], e_off[i]);
            end
        end
        check(bad == 0, $sformatf("%s R7 request stream: got %0d requests, exp %0d",
              tag, g_addr.size(), e_addr.size()));
        check(g_dir_bad == 0, $sformatf("%s R11 write flag: got %0d wrong, exp 0", tag, g_dir_bad));
        check(g_short == e_short, $sformatf("%s R8/R9 short flag: got %0d, exp %0d",
              tag, g_short, e_short));
    endtask

    task automatic fill_tail();
        for (int i = 0; i < TBL_N; i++) tbl[i] = mk_desc(32'hDEAD_0000, 16'd4, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fill_tail();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        check(!busy_o && !done_o && !short_o && !desc_req_o && !mreq_valid_o,
              $sformatf("R13 idle after reset: got busy=%0d done=%0d req=%0d valid=%0d, exp all 0",
                        busy_o, done_o, desc_req_o, mreq_valid_o));

        // R7 R1: one terminated region split into bursts
        fill_tail();
        tbl[0] = mk_desc(32'h1000_0100, 16'd600, 1'b1);
        run_case(32'h0000_8000, 600, 1'b0, "R1");

        // R2: odd count field, bit 0 dropped
        fill_tail();
        tbl[0] = mk_desc(32'h2000_0000, 16'h0065, 1'b1);
        run_case(32'h0000_9000, 100, 1'b0, "R2");

        // R3 R9: zero count is 64 KiB, buffer larger than table
        fill_tail();
        tbl[0] = mk_desc(32'h3000_0000, 16'd0, 1'b1);
        run_case(32'h0001_0000, 70000, 1'b1, "R3");

        // R4: final flag on first entry stops the walk
        fill_tail();
        tbl[0] = mk_desc(32'h4000_0000, 16'd64, 1'b1);
        tbl[1] = mk_desc(32'h4100_0000, 16'd64, 1'b1);
        run_case(32'h0002_0000, 500, 1'b0, "R4");

        // R8: buffer exhausted before the table ends
        fill_tail();
        tbl[0] = mk_desc(32'h5000_0000, 16'd100, 1'b0);
        tbl[1] = mk_desc(32'h5100_0000, 16'd100, 1'b0);
        tbl[2] = mk_desc(32'h5200_0000, 16'd100, 1'b1);
        run_case(32'h0003_0000, 150, 1'b1, "R8");

        // R8: zero byte count, no fetch
        run_case(32'h0003_0000, 0, 1'b0, "R8");

        // R6: unterminated table stops after one page
        for (int i = 0; i < TBL_N; i++) tbl[i] = mk_desc(32'h6000_0000 + 32'(i * 16), 16'd2, 1'b0);
        run_case(32'h0004_0000, 5000, 1'b0, "R6");

        // R10: previous walk left bytes in a region; new walk fetches fresh
        fill_tail();
        tbl[0] = mk_desc(32'h7000_0000, 16'd600, 1'b1);
        run_case(32'h0005_0000, 300, 1'b1, "R10");
        tbl[0] = mk_desc(32'h7100_0000, 16'd40, 1'b0);
        tbl[1] = mk_desc(32'h7200_0000, 16'd40, 1'b1);
        run_case(32'h0005_1000, 80, 1'b0, "R10");

        // R11 R5: multi-entry table, device-to-memory
        fill_tail();
        for (int i = 0; i < 5; i++) tbl[i] = mk_desc(32'h8000_0000 + 32'(i * 32'h1000), 16'(200 + i * 2), i == 4);
        run_case(32'h0006_0004, 1100, 1'b1, "R11");

        // R12: random tables with random stalls
        for (int n = 0; n < 30; n++) begin
            int nd;
            fill_tail();
            nd = 1 + int'($urandom % 6);
            for (int i = 0; i < nd; i++) begin
                logic [15:0] c;
                c = (($urandom % 8) == 0) ? 16'd0 : 16'($urandom & 32'h0FFF);
                tbl[i] = mk_desc($urandom, c, (i == nd - 1) && (($urandom % 4) != 0));
            end
            run_case($urandom & 32'hFFFF_FFF0, int'($urandom % 8000), 1'($urandom), "R12");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule